// File: doc/BRIEF.md
# Prescaled Modulo Up-Counter Timer

The block is a free-running 16-bit up-counter that wraps at a value software chooses. A 3-bit divider select slows the count clock by a power of two. When the count reaches the chosen limit, the counter returns to zero and a sticky overflow flag sets. If software has enabled it, an interrupt request follows from that flag. The counter halts at reset and runs only after software clears the halt bit.

A processor reaches the block over a small byte-wide register port with an address, a read strobe, a write strobe, write data and combinational read data. Each strobe takes effect at the rising clock edge in the cycle where it is high. The block clears the flag only by a two-step handshake: a read that sees the flag set, then a write with a zero in the flag position. An overflow that lands between those two steps keeps the flag, so a pending interrupt cannot be lost.

Top module: `modtimer`

## Requirements
- R1: Register addresses are 0 = control/status, 1 = count high byte, 2 = count low byte, 3 = limit high byte, 4 = limit low byte. After reset, control/status reads 0x20, the count reads 0x0000, the limit reads 0xFFFF and irq is 0.
- R2: While the halt bit (control bit 5) is 1, the count does not change.
- R3: With divider select value k in control bits 2..0, the count advances once every 2^k running clocks, counted from the last counter clear.
- R4: On the advance where the count equals the limit, the count becomes 0 and the overflow flag (control bit 7) reads 1 from that same edge on.
- R5: A write to control with bit 7 = 0 clears the flag only if a control read that saw the flag set came after the last control write. Otherwise the flag stays set.
- R6: An overflow after the arming read and before the zero-write cancels the arming, and the zero-write leaves the flag set.
- R7: Writing 1 to bit 7 never sets the flag and never clears it.
- R8: irq is 1 exactly when the flag and the interrupt enable (control bit 6) are both 1.
- R9: Writing 1 to control bit 4 clears the count and the divider phase to zero. Bits 4 and 3 always read 0.
- R10: Reading the count high byte captures the low byte. The next low-byte read returns that captured byte, and later low-byte reads return the live value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register address |
| rdEn | input | 1 | Read strobe, side effects at the clock edge |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Overflow interrupt request |

## Verification
A wrong arming state shows only at the next zero-write: the flag clears when it should stay, or stays when it should clear. The error is visible on the control read and on irq in the cycle after that write. A wrong divider phase or counter value appears at the next count read as an off-by-some count. A missed or doubled wrap shows one edge later as a flag that disagrees with the computed number of advances. A stale capture register shows on the first low-byte read after a high-byte read.

// File: rtl/modtimer_pkg.sv
package modtimer_pkg;
  localparam int unsigned TM_BYTE_W = 8;
  localparam int unsigned TM_ADDR_W = 3;
  localparam int unsigned TM_PS_W   = 3;

  localparam logic [TM_ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [TM_ADDR_W-1:0] ADR_CNT_HI = 3'd1;
  localparam logic [TM_ADDR_W-1:0] ADR_CNT_LO = 3'd2;
  localparam logic [TM_ADDR_W-1:0] ADR_MOD_HI = 3'd3;
  localparam logic [TM_ADDR_W-1:0] ADR_MOD_LO = 3'd4;

  // control bit positions
  localparam int unsigned BIT_FLAG  = 7;
  localparam int unsigned BIT_IEN   = 6;
  localparam int unsigned BIT_HALT  = 5;
  localparam int unsigned BIT_CLEAR = 4;

  typedef struct packed {
    logic                 halt;
    logic [TM_PS_W-1:0]   psSel;
    logic                 cntClear;
    logic                 modHiWr;
    logic                 modLoWr;
    logic                 cntHiRd;
    logic                 cntLoRd;
    logic [TM_BYTE_W-1:0] wrByte;
  } dpStrobes_t;
endpackage

// File: rtl/modtimer_dp.sv
module modtimer_dp
  import modtimer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobes_t           strb,
  output logic                 ovfPulse,
  output logic [TM_BYTE_W-1:0] cntHiByte,
  output logic [TM_BYTE_W-1:0] cntLoByte,
  output logic [TM_BYTE_W-1:0] modHiByte,
  output logic [TM_BYTE_W-1:0] modLoByte
);
  localparam int unsigned PRE_W = (1 << TM_PS_W) - 1;

  logic [PRE_W-1:0]     preQ, preMask;
  logic [CNT_W-1:0]     cntQ, modQ;
  logic [TM_BYTE_W-1:0] loLatchQ;
  logic                 latchValidQ;
  logic                 tick, atLimit;

  always_comb begin
    preMask  = ~({PRE_W{1'b1}} << strb.psSel);
    tick     = !strb.halt && ((preQ & preMask) == preMask);
    atLimit  = (cntQ == modQ);
    ovfPulse = tick && atLimit && !strb.cntClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ <= '0;
      cntQ <= '0;
    end else if (strb.cntClear) begin
      preQ <= '0;
      cntQ <= '0;
    end else if (!strb.halt) begin
      preQ <= preQ + 1'b1;
      if (tick) cntQ <= atLimit ? '0 : cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modQ <= '1;
    end else begin
      if (strb.modHiWr) modQ[CNT_W-1:TM_BYTE_W] <= strb.wrByte;
      if (strb.modLoWr) modQ[TM_BYTE_W-1:0]     <= strb.wrByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loLatchQ    <= '0;
      latchValidQ <= 1'b0;
    end else if (strb.cntHiRd) begin
      loLatchQ    <= cntQ[TM_BYTE_W-1:0];
      latchValidQ <= 1'b1;
    end else if (strb.cntLoRd) begin
      latchValidQ <= 1'b0;
    end
  end

  assign cntHiByte = cntQ[CNT_W-1:TM_BYTE_W];
  assign cntLoByte = latchValidQ ? loLatchQ : cntQ[TM_BYTE_W-1:0];
  assign modHiByte = modQ[CNT_W-1:TM_BYTE_W];
  assign modLoByte = modQ[TM_BYTE_W-1:0];

  p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.halt && !strb.cntClear |=> $stable(cntQ));
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> cntQ == '0);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClear |=> (cntQ == '0) && (preQ == '0));
  p_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntHiRd |=> cntLoByte == $past(cntQ[TM_BYTE_W-1:0]));
endmodule

// File: rtl/modtimer_ctrl.sv
module modtimer_ctrl
  import modtimer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [TM_ADDR_W-1:0] addr,
  input  logic                 rdEn,
  input  logic                 wrEn,
  input  logic [TM_BYTE_W-1:0] wrData,
  input  logic                 ovfPulse,
  input  logic [TM_BYTE_W-1:0] cntHiByte,
  input  logic [TM_BYTE_W-1:0] cntLoByte,
  input  logic [TM_BYTE_W-1:0] modHiByte,
  input  logic [TM_BYTE_W-1:0] modLoByte,
  output dpStrobes_t           strb,
  output logic [TM_BYTE_W-1:0] rdData,
  output logic                 irq
);
  logic               flagQ, irqEnQ, haltQ, armedQ;
  logic [TM_PS_W-1:0] psQ;
  logic               ctrlWr, ctrlRd;

  assign ctrlWr = wrEn && (addr == ADR_CTRL);
  assign ctrlRd = rdEn && (addr == ADR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEnQ <= 1'b0;
      haltQ  <= 1'b1;
      psQ    <= '0;
    end else if (ctrlWr) begin
      irqEnQ <= wrData[BIT_IEN];
      haltQ  <= wrData[BIT_HALT];
      psQ    <= wrData[TM_PS_W-1:0];
    end
  end

  // flag: overflow wins over a clearing write in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= 1'b0;
      armedQ <= 1'b0;
    end else begin
      if (ovfPulse)                                    flagQ <= 1'b1;
      else if (ctrlWr && !wrData[BIT_FLAG] && armedQ)  flagQ <= 1'b0;

      if (ovfPulse || ctrlWr)    armedQ <= 1'b0;
      else if (ctrlRd && flagQ)  armedQ <= 1'b1;
    end
  end

  always_comb begin
    strb.halt     = haltQ;
    strb.psSel    = psQ;
    strb.cntClear = ctrlWr && wrData[BIT_CLEAR];
    strb.modHiWr  = wrEn && (addr == ADR_MOD_HI);
    strb.modLoWr  = wrEn && (addr == ADR_MOD_LO);
    strb.cntHiRd  = rdEn && (addr == ADR_CNT_HI);
    strb.cntLoRd  = rdEn && (addr == ADR_CNT_LO);
    strb.wrByte   = wrData;
  end

  always_comb begin
    case (addr)
      ADR_CTRL:   rdData = {flagQ, irqEnQ, haltQ, 2'b00, psQ};
      ADR_CNT_HI: rdData = cntHiByte;
      ADR_CNT_LO: rdData = cntLoByte;
      ADR_MOD_HI: rdData = modHiByte;
      ADR_MOD_LO: rdData = modLoByte;
      default:    rdData = '0;
    endcase
  end

  assign irq = flagQ && irqEnQ;

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> flagQ);
  p_unarmed_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    flagQ && !armedQ |=> flagQ);
  p_ovf_disarm_r6: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> !armedQ);
  p_write_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && wrData[BIT_FLAG] && !ovfPulse |=> flagQ == $past(flagQ));
endmodule

// File: rtl/modtimer.sv
module modtimer
  import modtimer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [TM_ADDR_W-1:0] addr,
  input  logic                 rdEn,
  input  logic                 wrEn,
  input  logic [TM_BYTE_W-1:0] wrData,
  output logic [TM_BYTE_W-1:0] rdData,
  output logic                 irq
);
  dpStrobes_t           strb;
  logic                 ovfPulse;
  logic [TM_BYTE_W-1:0] cntHiByte, cntLoByte, modHiByte, modLoByte;

  modtimer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .ovfPulse(ovfPulse), .cntHiByte(cntHiByte),
    .cntLoByte(cntLoByte), .modHiByte(modHiByte), .modLoByte(modLoByte),
    .strb(strb), .rdData(rdData), .irq(irq)
  );

  modtimer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ovfPulse(ovfPulse),
    .cntHiByte(cntHiByte), .cntLoByte(cntLoByte),
    .modHiByte(modHiByte), .modLoByte(modLoByte)
  );
endmodule

// File: tb/modtimer_test.sv
module modtimer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irq;
  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [2:0] a;
    logic [7:0] v;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  modtimer uut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  // driver: queue the expected byte, then strobe the read
  task automatic busRead(input logic [2:0] a, input logic [7:0] v, input string tag);
    expItem_t it;
    @(posedge clk); #1;
    it.a = a; it.v = v; it.tag = tag;
    expQ.push_back(it);
    addr = a; rdEn = 1'b1;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  // exactly n clock edges with the halt bit clear, then halt again
  task automatic runTicks(input logic [7:0] ctrlVal, input int n);
    @(posedge clk); #1;
    addr = 3'd0; wrData = ctrlVal; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
    repeat (n - 1) @(posedge clk);
    #1;
    addr = 3'd0; wrData = ctrlVal | 8'h20; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic checkIrq(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq got %0b exp %0b", tag, irq, exp);
    end
  endtask

  // monitor: compare each read against the head of the scoreboard
  always @(negedge clk) begin
    if (rdEn) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected read addr %0d got %02h exp none", addr, rdData);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (rdData !== it.v || addr !== it.a) begin
          errors++;
          $display("FAIL %s addr %0d got %02h exp %02h", it.tag, it.a, rdData, it.v);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired got running exp finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    busRead(3'd0, 8'h20, "R1");
    busRead(3'd1, 8'h00, "R1");
    busRead(3'd2, 8'h00, "R1");
    busRead(3'd3, 8'hFF, "R1");
    busRead(3'd4, 8'hFF, "R1");
    checkIrq(1'b0, "R1");

    // R2 halted after reset; R7 writing 1 to the flag does not set it
    repeat (20) @(posedge clk);
    busRead(3'd2, 8'h00, "R2");
    busWrite(3'd0, 8'hA0);
    busRead(3'd0, 8'h20, "R7");

    // R9 clear bit reads 0; R3 divide by 4 then by 1
    busWrite(3'd0, 8'h32);
    busRead(3'd0, 8'h22, "R9");
    runTicks(8'h82, 10);
    busRead(3'd1, 8'h00, "R3");
    busRead(3'd2, 8'h02, "R3");
    runTicks(8'h80, 5);
    busRead(3'd2, 8'h07, "R3");

    // R9 counter clear
    busWrite(3'd0, 8'h30);
    busRead(3'd2, 8'h00, "R9");
    busRead(3'd0, 8'h20, "R9");

    // R4 wrap at limit 3
    busWrite(3'd3, 8'h00);
    busWrite(3'd4, 8'h03);
    runTicks(8'h80, 3);
    busRead(3'd2, 8'h03, "R4");
    busRead(3'd0, 8'h20, "R4");
    runTicks(8'h80, 1);
    busRead(3'd0, 8'hA0, "R4");
    busRead(3'd2, 8'h00, "R4");
    checkIrq(1'b0, "R8");

    // R8 enable raises irq; write disarms the earlier read
    busWrite(3'd0, 8'hE0);
    checkIrq(1'b1, "R8");

    // R5 zero-write without arming keeps, with arming clears
    busWrite(3'd0, 8'h60);
    busRead(3'd0, 8'hE0, "R5");
    busWrite(3'd0, 8'h60);
    busRead(3'd0, 8'h60, "R5");
    checkIrq(1'b0, "R8");

    // R6 overflow between arming read and zero-write
    runTicks(8'hC0, 4);
    checkIrq(1'b1, "R8");
    busWrite(3'd0, 8'hC0);
    busRead(3'd0, 8'hC0, "R6");
    repeat (2) @(posedge clk);
    busWrite(3'd0, 8'h60);
    busRead(3'd0, 8'hE0, "R6");
    busRead(3'd2, 8'h02, "R6");

    // R10 coherent high/low read
    busWrite(3'd0, 8'h30);
    busWrite(3'd3, 8'hFF);
    busWrite(3'd4, 8'hFF);
    runTicks(8'h80, 300);
    busRead(3'd1, 8'h01, "R10");
    runTicks(8'h80, 5);
    busRead(3'd2, 8'h2C, "R10");
    busRead(3'd2, 8'h31, "R10");

    repeat (3) @(posedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left got %0d exp 0", expQ.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule